// File: doc/BRIEF.md
# JTAG TAP Scan Sequencer

This block runs single-device JTAG scans for a debug controller. A command asks for one of three operations: load an instruction, scan a data register, or reset the TAP. The sequencer then drives TCK, TMS and TDI and samples TDO until the TAP is back in Run-Test/Idle. Each operation starts and ends in Run-Test/Idle. The TMS patterns that enter and leave the shift states are fixed, so the caller supplies only the payload, its length and the number of extra idle clocks to add after a data scan.

The block remembers the last instruction it shifted in. A request for the same instruction finishes at once without toggling TCK. An instruction that does not fit the 5-bit instruction register is rejected, and so is a data length outside 1 to 64. Both are reported by an error flag on the completion pulse.

TCK is derived from a one-cycle strobe. Each strobe toggles TCK. On the strobe that raises TCK the block samples TDO. On the strobe that lowers TCK it presents the next TMS/TDI bit. One TCK period therefore spans two strobes.

Top module: `jtag_scan_seq`

## Requirements
- R1: A data scan starts from Idle with TMS 1, 0, 0 on its first three TCK periods. TDI is 0 on these periods.
- R2: An instruction scan starts from Idle with TMS 1, 1, 0, 0 on its first four TCK periods. TDI is 0 on these periods.
- R3: A scan of n bits carries TMS=0 on its first n-1 shift periods and TMS=1 on its last shift period. Two more periods follow with TMS 1 then 0. Outside a command, TMS and TDI rest at 0.
- R4: Shift data goes out on TDI least-significant bit first, one bit per TCK period. For a data scan, the TDO value sampled on shift period j (j counted from 0, right after the entry periods) is stored in bit j of `rd_data`. Bits at and above n read 0.
- R5: TDI is 0 on every entry, exit and idle-pad period. During the shift periods it carries exactly the payload bits.
- R6: A data scan is followed by `idle_cycles` (0 to 255) extra periods with TMS=0 and TDI=0. An instruction scan gets none.
- R7: An instruction request above 0x1F completes with `err`=1 and no TCK activity, and it leaves the cached instruction unchanged.
- R8: The cached instruction is 1 after reset and takes the value of each instruction actually scanned. A request equal to the cache completes with `err`=0 and no TCK activity.
- R9: The TAP reset command (op 0) issues six TCK periods with TMS 1, 1, 1, 1, 1, 0 and TDI 0, and it does not change the instruction cache.
- R10: Operation codes are 0 TAP reset, 1 instruction scan, 2 data scan. A data length of 0 or above 64, or op code 3, completes with `err`=1 and no TCK activity.
- R11: `busy` is high from the cycle after a scan is accepted until the TAP is back in Idle. `done` is a one-cycle pulse at completion. Commands are taken only when `busy` and `done` are both low, and TCK is low whenever `busy` is low.
- R12: TDO is sampled on the strobe that raises TCK. TMS and TDI change only on the strobe that lowers TCK, so they hold still while TCK is high.
- R13: During and right after reset, TCK, TMS, TDI, `busy`, `done`, `err` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tck_stb | input | 1 | One-cycle strobe; each one toggles TCK while a scan runs |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 TAP reset, 1 instruction scan, 2 data scan, 3 invalid |
| cmd_ir | input | 8 | Requested instruction (legal range 0 to 0x1F) |
| cmd_len | input | 7 | Data scan length in bits (1 to 64) |
| cmd_wdata | input | 64 | Data scan payload, LSB shifted first |
| idle_cycles | input | 8 | Extra Idle periods after a data scan |
| tdo | input | 1 | Test data from the target |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command rejected; valid with `done` |
| rd_data | output | 64 | Captured TDO bits, LSB first |

## Verification
The bench records TMS and TDI on every rising TCK edge and compares the whole stream against the expected entry, shift, exit and pad patterns. Several cases are chosen because a plausible bug breaks them. With a one-bit scan, a design that ignored the last-bit rule would miss the TMS=1 that must fall on the very first shift period. A 64-bit scan with 255 idle periods catches a counter that is one bit too narrow, because it would wrap or cut the pad short.

TDO is driven as a function of the rising-edge count. A design that sampled on the falling edge, or started capturing one period early, would return `rd_data` shifted by one bit. The cache cases check three things: the reset value of 1 leads to an immediate completion, an out-of-range request leaves the cache unchanged, and a TAP reset also leaves it unchanged. A design that updated the cache on a rejected instruction would scan again when it should skip.

// File: rtl/jtag_seq_pkg.sv
package jtag_seq_pkg;

  typedef enum logic [1:0] {
    OP_TAPRST = 2'd0,
    OP_IR     = 2'd1,
    OP_DR     = 2'd2,
    OP_BAD    = 2'd3
  } seq_op_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ENTRY = 3'd1,
    PH_SHIFT = 3'd2,
    PH_EXIT  = 3'd3,
    PH_PAD   = 3'd4,
    PH_RST   = 3'd5
  } seq_phase_e;

endpackage

// File: rtl/jtag_rst_sync.sv
module jtag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic run,
  output logic tck,
  output logic rise,
  output logic fall
);

  logic tck_q;
  logic tck_d;

  assign rise = stb && run && !tck_q;
  assign fall = stb && run && tck_q;

  always_comb begin
    tck_d = tck_q;
    if (rise) begin
      tck_d = 1'b1;
    end else if (fall) begin
      tck_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_q <= 1'b0;
    end else begin
      tck_q <= tck_d;
    end
  end

  assign tck = tck_q;

endmodule

// File: rtl/jtag_ir_cache.sv
module jtag_ir_cache #(
  parameter int          IR_W      = 5,
  parameter logic [IR_W-1:0] RESET_VAL = IR_W'(1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IR_W-1:0] ir_in,
  output logic [IR_W-1:0] ir_cur
);

  logic [IR_W-1:0] ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= RESET_VAL;
    end else if (load) begin
      ir_q <= ir_in;
    end
  end

  assign ir_cur = ir_q;

endmodule

// File: rtl/jtag_capture.sv
module jtag_capture #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [IDX_W-1:0]  idx,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data
);

  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] cap_d;

  always_comb begin
    cap_d = cap_q;
    if (clear) begin
      cap_d = '0;
    end else if (sample) begin
      cap_d[idx] = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (clear || sample) begin
      cap_q <= cap_d;
    end
  end

  assign data = cap_q;

endmodule

// File: rtl/jtag_scan_fsm.sv
module jtag_scan_fsm
  import jtag_seq_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int LEN_W    = $clog2(DATA_W + 1),
  parameter int PAD_W    = 8,
  parameter int RST_ONES = 5,
  parameter int IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  seq_op_e           start_op,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [DATA_W-1:0] start_data,
  input  logic [PAD_W-1:0]  start_idle,
  input  logic              adv,
  output logic              busy,
  output logic              finish,
  output logic              tms,
  output logic              tdi,
  output logic              shift_act,
  output logic [IDX_W-1:0]  shift_idx
);

  localparam int CNT_W = (LEN_W > PAD_W) ? LEN_W : PAD_W;
  localparam logic [CNT_W-1:0] DR_ENTRY_LAST = CNT_W'(2);
  localparam logic [CNT_W-1:0] IR_ENTRY_LAST = CNT_W'(3);
  localparam logic [CNT_W-1:0] IR_TMS_ONES   = CNT_W'(2);
  localparam logic [CNT_W-1:0] EXIT_LAST     = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_LAST      = CNT_W'(RST_ONES);
  localparam logic [CNT_W-1:0] RST_TMS_ONES  = CNT_W'(RST_ONES);

  seq_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              is_ir_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] data_q;
  logic [PAD_W-1:0]  idle_q;

  logic [CNT_W-1:0]  len_last;
  logic [CNT_W-1:0]  pad_last;
  logic              tms_c, tdi_c, shift_c, last_c, fin_c;

  assign len_last = CNT_W'(len_q) - CNT_W'(1);
  assign pad_last = CNT_W'(idle_q) - CNT_W'(1);

  // Per-period decode of the current TMS/TDI bit
  always_comb begin
    tms_c   = 1'b0;
    tdi_c   = 1'b0;
    shift_c = 1'b0;
    last_c  = 1'b0;
    case (phase_q)
      PH_ENTRY: begin
        tms_c  = is_ir_q ? (cnt_q < IR_TMS_ONES) : (cnt_q == '0);
        last_c = (cnt_q == (is_ir_q ? IR_ENTRY_LAST : DR_ENTRY_LAST));
      end
      PH_SHIFT: begin
        tms_c   = (cnt_q == len_last);
        tdi_c   = data_q[cnt_q[IDX_W-1:0]];
        shift_c = 1'b1;
        last_c  = (cnt_q == len_last);
      end
      PH_EXIT: begin
        tms_c  = (cnt_q == '0);
        last_c = (cnt_q == EXIT_LAST);
      end
      PH_PAD: begin
        last_c = (cnt_q == pad_last);
      end
      PH_RST: begin
        tms_c  = (cnt_q < RST_TMS_ONES);
        last_c = (cnt_q == RST_LAST);
      end
      default: begin
      end
    endcase
  end

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    fin_c   = 1'b0;
    if (start) begin
      phase_d = (start_op == OP_TAPRST) ? PH_RST : PH_ENTRY;
      cnt_d   = '0;
    end else if (adv && (phase_q != PH_IDLE)) begin
      if (!last_c) begin
        cnt_d = cnt_q + CNT_W'(1);
      end else begin
        cnt_d = '0;
        case (phase_q)
          PH_ENTRY: phase_d = PH_SHIFT;
          PH_SHIFT: phase_d = PH_EXIT;
          PH_EXIT: begin
            if (!is_ir_q && (idle_q != '0)) begin
              phase_d = PH_PAD;
            end else begin
              phase_d = PH_IDLE;
              fin_c   = 1'b1;
            end
          end
          default: begin
            phase_d = PH_IDLE;
            fin_c   = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_ir_q <= 1'b0;
      len_q   <= '0;
      data_q  <= '0;
      idle_q  <= '0;
    end else if (start) begin
      is_ir_q <= (start_op == OP_IR);
      len_q   <= start_len;
      data_q  <= start_data;
      idle_q  <= start_idle;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign finish    = fin_c;
  assign tms       = tms_c;
  assign tdi       = tdi_c;
  assign shift_act = shift_c;
  assign shift_idx = cnt_q[IDX_W-1:0];

endmodule

// File: rtl/jtag_scan_seq.sv
module jtag_scan_seq
  import jtag_seq_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int IR_W     = 5,
  parameter int IR_REQ_W = 8,
  parameter int PAD_W    = 8,
  parameter int RST_ONES = 5,
  parameter int IR_INIT  = 1,
  parameter int LEN_W    = $clog2(DATA_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tck_stb,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [IR_REQ_W-1:0] cmd_ir,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic [DATA_W-1:0]   cmd_wdata,
  input  logic [PAD_W-1:0]    idle_cycles,
  input  logic                tdo,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [DATA_W-1:0]   rd_data
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

  logic rst_n_s;
  logic run, rise, fall;
  logic fsm_finish, shift_act;
  logic [IDX_W-1:0] shift_idx;
  logic [IR_W-1:0]  ir_cur;
  logic done_q, err_q;

  seq_op_e op_in;
  logic accept, bad_ir, bad_dr, bad_op, reject, ir_hit, launch;
  logic [LEN_W-1:0]  launch_len;
  logic [DATA_W-1:0] launch_data;

  jtag_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Command decode
  always_comb begin
    op_in  = seq_op_e'(cmd_op);
    accept = cmd_valid && !run && !done_q;
    bad_op = (op_in == OP_BAD);
    bad_ir = (op_in == OP_IR) && (cmd_ir[IR_REQ_W-1:IR_W] != '0);
    bad_dr = (op_in == OP_DR) && ((cmd_len == '0) || (cmd_len > LEN_MAX));
    reject = accept && (bad_op || bad_ir || bad_dr);
    ir_hit = accept && (op_in == OP_IR) && !bad_ir && (cmd_ir[IR_W-1:0] == ir_cur);
    launch = accept && !reject && !ir_hit;
    if (op_in == OP_IR) begin
      launch_len  = LEN_W'(IR_W);
      launch_data = DATA_W'(cmd_ir[IR_W-1:0]);
    end else begin
      launch_len  = cmd_len;
      launch_data = cmd_wdata;
    end
  end

  jtag_ir_cache #(
    .IR_W      (IR_W),
    .RESET_VAL (IR_W'(IR_INIT))
  ) u_ir_cache (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load   (launch && (op_in == OP_IR)),
    .ir_in  (cmd_ir[IR_W-1:0]),
    .ir_cur (ir_cur)
  );

  jtag_tck_gen u_tck_gen (
    .clk   (clk),
    .rst_n (rst_n_s),
    .stb   (tck_stb),
    .run   (run),
    .tck   (tck),
    .rise  (rise),
    .fall  (fall)
  );

  jtag_scan_fsm #(
    .DATA_W   (DATA_W),
    .LEN_W    (LEN_W),
    .PAD_W    (PAD_W),
    .RST_ONES (RST_ONES),
    .IDX_W    (IDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (launch),
    .start_op   (op_in),
    .start_len  (launch_len),
    .start_data (launch_data),
    .start_idle (idle_cycles),
    .adv        (fall),
    .busy       (run),
    .finish     (fsm_finish),
    .tms        (tms),
    .tdi        (tdi),
    .shift_act  (shift_act),
    .shift_idx  (shift_idx)
  );

  jtag_capture #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_capture (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clear  (launch && (op_in != OP_TAPRST)),
    .sample (rise && shift_act),
    .idx    (shift_idx),
    .bit_in (tdo),
    .data   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= reject || ir_hit || fsm_finish;
      err_q  <= reject;
    end
  end

  assign busy = run;
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/jtag_scan_seq_chk.sv
module jtag_scan_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic busy,
  input logic done,
  input logic err
);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_tck_low_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  assert_err_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_rest_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tms && !tdi));

  assert_pins_hold_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi)));

endmodule

bind jtag_scan_seq jtag_scan_seq_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tck   (tck),
  .tms   (tms),
  .tdi   (tdi),
  .busy  (busy),
  .done  (done),
  .err   (err)
);

// File: tb/test_jtag_scan_seq.sv
`timescale 1ns/1ps
module test_jtag_scan_seq;

  localparam int LIM = 6000;

  logic        clk;
  logic        rst_n;
  logic        tck_stb;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_ir;
  logic [6:0]  cmd_len;
  logic [63:0] cmd_wdata;
  logic [7:0]  idle_cycles;
  logic        tdo;
  logic        tck, tms, tdi, busy, done, err;
  logic [63:0] rd_data;

  int n_chk;
  int n_fail;

  int   edge_n;
  bit   rec_tms [0:1023];
  bit   rec_tdi [0:1023];
  bit   exp_tms [0:1023];
  bit   exp_tdi [0:1023];
  int   exp_n;
  logic [63:0] tdo_pat;

  int   hold_viol;
  logic prev_tck, prev_tms, prev_tdi;

  logic r_err, r_busy, r_done_again, r_timeout;

  jtag_scan_seq i_jtag_scan_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tck_stb     (tck_stb),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_ir      (cmd_ir),
    .cmd_len     (cmd_len),
    .cmd_wdata   (cmd_wdata),
    .idle_cycles (idle_cycles),
    .tdo         (tdo),
    .tck         (tck),
    .tms         (tms),
    .tdi         (tdi),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .rd_data     (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Strobe high on every other clock cycle
  always @(negedge clk) begin
    if (!rst_n) tck_stb <= 1'b0;
    else        tck_stb <= ~tck_stb;
  end

  // Target model: TDO follows the rising-edge count
  assign tdo = (edge_n >= 3 && edge_n < 67) ? tdo_pat[edge_n - 3] : 1'b0;

  always @(posedge tck) begin
    if (edge_n < 1024) begin
      rec_tms[edge_n] = tms;
      rec_tdi[edge_n] = tdi;
    end
    edge_n = edge_n + 1;
  end

  // R12 monitor: pins must not move while TCK stays high
  always @(negedge clk) begin
    if (rst_n && tck && prev_tck && ((tms != prev_tms) || (tdi != prev_tdi)))
      hold_viol = hold_viol + 1;
    prev_tck = tck;
    prev_tms = tms;
    prev_tdi = tdi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic push(input bit t, input bit d);
    exp_tms[exp_n] = t;
    exp_tdi[exp_n] = d;
    exp_n = exp_n + 1;
  endtask

  task automatic build_dr(input int len, input logic [63:0] d, input int idle);
    exp_n = 0;
    push(1, 0); push(0, 0); push(0, 0);
    for (int j = 0; j < len; j++) push(j == len - 1, d[j]);
    push(1, 0); push(0, 0);
    for (int j = 0; j < idle; j++) push(0, 0);
  endtask

  task automatic build_ir(input logic [4:0] v);
    exp_n = 0;
    push(1, 0); push(1, 0); push(0, 0); push(0, 0);
    for (int j = 0; j < 5; j++) push(j == 4, v[j]);
    push(1, 0); push(0, 0);
  endtask

  task automatic build_rst();
    exp_n = 0;
    for (int j = 0; j < 5; j++) push(1, 0);
    push(0, 0);
  endtask

  task automatic cmp_seq(input string req);
    int bad;
    bad = -1;
    chk(edge_n == exp_n, req, "TCK period count", 64'(edge_n), 64'(exp_n));
    if (edge_n == exp_n) begin
      for (int k = 0; k < exp_n; k++)
        if (bad < 0 && (rec_tms[k] != exp_tms[k] || rec_tdi[k] != exp_tdi[k])) bad = k;
      if (bad >= 0)
        chk(1'b0, req, $sformatf("TMS/TDI at period %0d", bad),
            {62'd0, rec_tms[bad], rec_tdi[bad]}, {62'd0, exp_tms[bad], exp_tdi[bad]});
      else
        chk(1'b1, req, "TMS/TDI stream", 64'd0, 64'd0);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] ir, input logic [6:0] len,
                         input logic [63:0] wd, input logic [7:0] idle);
    int cyc;
    @(negedge clk);
    edge_n      = 0;
    cmd_op      = op;
    cmd_ir      = ir;
    cmd_len     = len;
    cmd_wdata   = wd;
    idle_cycles = idle;
    cmd_valid   = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_busy    = busy;
    cyc       = 0;
    while (!done && cyc < LIM) begin
      @(negedge clk);
      cyc = cyc + 1;
    end
    r_timeout = (cyc >= LIM);
    if (r_timeout) begin
      n_fail = n_fail + 1;
      $display("FAIL R11 watchdog: done never seen, actual=0 expected=1");
    end
    r_err = err;
    @(negedge clk);
    r_done_again = done;
  endtask

  task automatic t_reset_state();
    chk(tck == 0 && tms == 0 && tdi == 0, "R13", "pins after reset", {61'd0, tck, tms, tdi}, 64'd0);
    chk(busy == 0 && done == 0 && err == 0, "R13", "flags after reset", {61'd0, busy, done, err}, 64'd0);
    chk(rd_data == 0, "R13", "rd_data after reset", rd_data, 64'd0);
  endtask

  task automatic t_ir_cache_reset();
    run_cmd(2'd1, 8'h01, 7'd0, 64'd0, 8'd0);
    chk(edge_n == 0 && r_err == 0, "R8", "instr 1 skipped after reset", 64'(edge_n), 64'd0);
  endtask

  task automatic t_tap_reset();
    build_rst();
    run_cmd(2'd0, 8'h00, 7'd0, 64'd0, 8'd7);
    cmp_seq("R9");
    chk(r_busy == 1 && r_err == 0, "R11", "busy during TAP reset", {62'd0, r_busy, r_err}, 64'd2);
    chk(r_done_again == 0, "R11", "done one cycle", 64'(r_done_again), 64'd0);
    run_cmd(2'd1, 8'h01, 7'd0, 64'd0, 8'd0);
    chk(edge_n == 0, "R9", "TAP reset keeps instr cache", 64'(edge_n), 64'd0);
  endtask

  task automatic t_ir_load();
    build_ir(5'h0E);
    run_cmd(2'd1, 8'h0E, 7'd0, 64'd0, 8'd9);
    cmp_seq("R2");
    chk(r_err == 0, "R2", "no error on instr load", 64'(r_err), 64'd0);
    run_cmd(2'd1, 8'h0E, 7'd0, 64'd0, 8'd0);
    chk(edge_n == 0 && r_err == 0, "R8", "repeat instr skipped", 64'(edge_n), 64'd0);
  endtask

  task automatic t_ir_range();
    run_cmd(2'd1, 8'h20, 7'd0, 64'd0, 8'd0);
    chk(r_err == 1 && edge_n == 0, "R7", "instr 0x20 rejected", {31'd0, r_err, 32'(edge_n)}, 64'h1_0000_0000);
    run_cmd(2'd1, 8'h0E, 7'd0, 64'd0, 8'd0);
    chk(edge_n == 0, "R7", "cache unchanged by rejected instr", 64'(edge_n), 64'd0);
    build_ir(5'h1F);
    run_cmd(2'd1, 8'h1F, 7'd0, 64'd0, 8'd0);
    cmp_seq("R8");
  endtask

  task automatic t_dr_read();
    tdo_pat = 64'h0000_0000_C3A5_1E69;
    build_dr(32, 64'd0, 0);
    run_cmd(2'd2, 8'h00, 7'd32, 64'd0, 8'd0);
    cmp_seq("R1");
    chk(rd_data == 64'h0000_0000_C3A5_1E69, "R4", "32-bit capture", rd_data, 64'h0000_0000_C3A5_1E69);
  endtask

  task automatic t_dr_write_idle();
    tdo_pat = 64'hFFFF_FFFF_FFFF_FF3C;
    build_dr(8, 64'hA5, 5);
    run_cmd(2'd2, 8'h00, 7'd8, 64'hFFFF_0000_0000_00A5, 8'd5);
    cmp_seq("R6");
    chk(rd_data == 64'h3C, "R4", "8-bit capture, upper bits clear", rd_data, 64'h3C);
  endtask

  task automatic t_dr_len1();
    tdo_pat = 64'h1;
    build_dr(1, 64'h1, 0);
    run_cmd(2'd2, 8'h00, 7'd1, 64'h1, 8'd0);
    cmp_seq("R3");
    chk(rd_data == 64'h1, "R4", "1-bit capture", rd_data, 64'h1);
  endtask

  task automatic t_dr_full();
    tdo_pat = 64'h8BAD_F00D_1357_9BDF;
    build_dr(64, 64'hDEAD_BEEF_0123_4567, 255);
    run_cmd(2'd2, 8'h00, 7'd64, 64'hDEAD_BEEF_0123_4567, 8'd255);
    cmp_seq("R5");
    chk(rd_data == 64'h8BAD_F00D_1357_9BDF, "R4", "64-bit capture", rd_data, 64'h8BAD_F00D_1357_9BDF);
  endtask

  task automatic t_dr_errors();
    run_cmd(2'd2, 8'h00, 7'd0, 64'd0, 8'd0);
    chk(r_err == 1 && edge_n == 0, "R10", "length 0 rejected", {31'd0, r_err, 32'(edge_n)}, 64'h1_0000_0000);
    run_cmd(2'd2, 8'h00, 7'd65, 64'd0, 8'd0);
    chk(r_err == 1 && edge_n == 0, "R10", "length 65 rejected", {31'd0, r_err, 32'(edge_n)}, 64'h1_0000_0000);
    run_cmd(2'd3, 8'h00, 7'd8, 64'd0, 8'd0);
    chk(r_err == 1 && edge_n == 0, "R10", "op 3 rejected", {31'd0, r_err, 32'(edge_n)}, 64'h1_0000_0000);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run did not end, actual=running expected=finished");
    finish_up();
  end

  initial begin
    n_chk = 0; n_fail = 0; edge_n = 0; hold_viol = 0;
    prev_tck = 0; prev_tms = 0; prev_tdi = 0;
    tdo_pat = 64'd0;
    rst_n = 1'b0; tck_stb = 1'b0; cmd_valid = 1'b0;
    cmd_op = 2'd0; cmd_ir = 8'd0; cmd_len = 7'd0; cmd_wdata = 64'd0; idle_cycles = 8'd0;
    repeat (4) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_ir_cache_reset();
    t_tap_reset();
    t_ir_load();
    t_ir_range();
    t_dr_read();
    t_dr_write_idle();
    t_dr_len1();
    t_dr_full();
    t_dr_errors();
    chk(hold_viol == 0, "R12", "TMS/TDI steady while TCK high", 64'(hold_viol), 64'd0);
    finish_up();
  end

endmodule